// File: doc/BRIEF.md
# Edge-Armed Output Latch

This block watches two level inputs sampled on the rising clock edge. A gate input forces the output low whenever it is low. While the gate is high, the first change of the toggle input, rising or falling, raises the output. The output then stays high, whatever the toggle input does, until the gate falls. The block suits a control path that must register "something moved while enabled" and hold that fact until the enable drops.

The inputs are meant to move one at a time, and only after the previous change has settled. State is a two-bit code. The three working codes are placed so that every single step flips exactly one bit. A move between the two far-apart codes therefore passes through the middle code for exactly one cycle. The output equation keeps that middle step from producing a pulse. If both inputs change between two samples, the state is frozen for one cycle and then follows the new inputs.

There is no data stream here, so there is no valid/ready handshake. All pins are plain control levels.

Top module: `toggle_catch_latch`

## Requirements
- R1: While `rst_i` is high, each rising edge loads `code_o` with 2'b11 if `tog_i` is 1, or with 2'b00 if `tog_i` is 0. `hit_o` is 0 after any such edge.
- R2: After a rising edge that samples `gate_i` = 0, `hit_o` is 0 until the next edge.
- R3: Suppose the gate is sampled 1 and `tog_i` is sampled at a new value, either polarity, with `code_o` at 2'b00 or 2'b11. Then `code_o` becomes 2'b10 and `hit_o` becomes 1 on the second edge after that change.
- R4: Once `hit_o` is 1, it stays 1 across every following edge that samples `gate_i` = 1, whatever `tog_i` does.
- R5: A falling `gate_i` drops `hit_o` to 0 right after the first edge that samples it.
- R6: Between consecutive edges out of reset, `code_o` changes in at most one bit.
- R7: The code steps from the old sample and the current code as follows:
  - 2'b00 goes to 2'b10 when toggle = 1, and otherwise stays.
  - 2'b11 goes to 2'b10 when toggle = 0, and otherwise stays.
  - 2'b10 stays while gate = 1. When gate = 0 it goes to 2'b11 if toggle = 1, or to 2'b00 if toggle = 0.
  - Code 2'b01 never appears.
  - `hit_o` is 1 only when the sampled gate is 1 and `code_o` is 2'b10.
- R8: A change of `gate_i` alone never raises `hit_o`.
- R9: When both inputs are sampled changed at the same edge, `code_o` holds through the next edge. It then steps from the new sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; inputs sampled on its rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| gate_i | input | 1 | Enable level; low forces the output low |
| tog_i | input | 1 | Level whose first change while enabled arms the output |
| hit_o | output | 1 | Armed output |
| code_o | output | 2 | Current two-bit state code |

## Verification
The bench targets four kinds of change.

- **Toggle falling under an enabled gate.** A design that only armed on a rising toggle would leave the output low here.
- **Toggle moving while the gate is low.** This sends the code across the middle step. A design with the wrong output equation would pulse the output for one cycle, and a design that jumped straight between the far codes would flip two bits.
- **Double input change.** A design without the freeze would step one cycle early, and the bench sees the output rise a cycle sooner than expected.
- **Gate rising with the toggle steady.** A design that armed on this would raise the output falsely.

// File: rtl/tcl_pkg.sv
package tcl_pkg;
  localparam int CODE_W = 2;
  localparam int IN_W   = 2;
  localparam int GATE_BIT = 1;
  localparam int TOG_BIT  = 0;

  typedef enum logic [CODE_W-1:0] {
    CODE_IDLE_LO = 2'b00,
    CODE_SPARE   = 2'b01,
    CODE_SET     = 2'b10,
    CODE_IDLE_HI = 2'b11
  } tcl_code_e;
endpackage

// File: rtl/tcl_sampler.sv
module tcl_sampler #(
  parameter int IN_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic [IN_W-1:0] raw_i,
  output logic [IN_W-1:0] smp_o,
  output logic            multi_o
);
  logic [IN_W-1:0] smp_q;
  logic            multi_q;
  logic [IN_W-1:0] diff;

  assign diff = raw_i ^ smp_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      smp_q   <= raw_i;
      multi_q <= 1'b0;
    end else begin
      smp_q   <= raw_i;
      multi_q <= ($countones(diff) > 1);
    end
  end

  assign smp_o   = smp_q;
  assign multi_o = multi_q;
endmodule

// File: rtl/tcl_step.sv
module tcl_step
  import tcl_pkg::*;
(
  input  tcl_code_e cur_i,
  input  logic      gate_i,
  input  logic      tog_i,
  output tcl_code_e nxt_o
);
  always_comb begin
    nxt_o = cur_i;
    unique case (cur_i)
      CODE_IDLE_LO: nxt_o = tog_i ? CODE_SET : CODE_IDLE_LO;
      CODE_IDLE_HI: nxt_o = tog_i ? CODE_IDLE_HI : CODE_SET;
      CODE_SET: begin
        if (gate_i)     nxt_o = CODE_SET;
        else if (tog_i) nxt_o = CODE_IDLE_HI;
        else            nxt_o = CODE_IDLE_LO;
      end
      CODE_SPARE:   nxt_o = tog_i ? CODE_IDLE_HI : CODE_IDLE_LO;
      default:      nxt_o = CODE_IDLE_LO;
    endcase
  end
endmodule

// File: rtl/toggle_catch_latch.sv
module toggle_catch_latch
  import tcl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              gate_i,
  input  logic              tog_i,
  output logic              hit_o,
  output logic [CODE_W-1:0] code_o
);
  logic [IN_W-1:0] raw;
  logic [IN_W-1:0] smp;
  logic            multi;
  tcl_code_e       code_q;
  tcl_code_e       code_nxt;

  assign raw[GATE_BIT] = gate_i;
  assign raw[TOG_BIT]  = tog_i;

  tcl_sampler #(.IN_W(IN_W)) u_smp (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .raw_i  (raw),
    .smp_o  (smp),
    .multi_o(multi)
  );

  tcl_step u_step (
    .cur_i (code_q),
    .gate_i(smp[GATE_BIT]),
    .tog_i (smp[TOG_BIT]),
    .nxt_o (code_nxt)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i)       code_q <= tog_i ? CODE_IDLE_HI : CODE_IDLE_LO;
    else if (!multi) code_q <= code_nxt;
  end

  assign hit_o  = smp[GATE_BIT] & (code_q == CODE_SET);
  assign code_o = code_q;
endmodule

// File: rtl/toggle_catch_latch_chk.sv
module toggle_catch_latch_chk (
  input logic       clk_i,
  input logic       rst_i,
  input logic       gate_i,
  input logic       tog_i,
  input logic       hit_o,
  input logic [1:0] code_o
);
  logic live_q;
  always_ff @(posedge clk_i) begin
    if (rst_i) live_q <= 1'b0;
    else       live_q <= 1'b1;
  end

  AST_LOW_GATE_CLEARS: assert property (@(posedge clk_i) disable iff (rst_i)
    live_q && !$past(gate_i) |-> !hit_o); // R2
  AST_SET_HOLDS: assert property (@(posedge clk_i) disable iff (rst_i)
    live_q && $past(hit_o) && $past(gate_i) |-> hit_o); // R4
  AST_ONE_BIT_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
    live_q |-> $countones(code_o ^ $past(code_o)) <= 1); // R6
  AST_NO_SPARE_CODE: assert property (@(posedge clk_i) disable iff (rst_i)
    live_q |-> code_o != 2'b01); // R7
  AST_DOUBLE_FREEZE: assert property (@(posedge clk_i) disable iff (rst_i)
    live_q && (gate_i != $past(gate_i)) && (tog_i != $past(tog_i))
      |-> ##2 $stable(code_o)); // R9
endmodule

bind toggle_catch_latch toggle_catch_latch_chk u_chk (
  .clk_i (clk_i),
  .rst_i (rst_i),
  .gate_i(gate_i),
  .tog_i (tog_i),
  .hit_o (hit_o),
  .code_o(code_o)
);

// File: tb/toggle_catch_latch_tb.sv
module toggle_catch_latch_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       gate = 1'b0;
  logic       tog = 1'b0;
  logic       hit;
  logic [1:0] code;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [1:0] m_code;
  logic       m_g, m_t, m_dbl;
  logic [1:0] prev_code;

  always #(CLK_PERIOD/2) clk = ~clk;

  toggle_catch_latch u_dut (
    .clk_i(clk), .rst_i(rst), .gate_i(gate), .tog_i(tog),
    .hit_o(hit), .code_o(code)
  );

  // step rule of R7
  function automatic logic [1:0] step_code(logic [1:0] c, logic g, logic t);
    case (c)
      2'b00:   return t ? 2'b10 : 2'b00;
      2'b11:   return t ? 2'b11 : 2'b10;
      2'b10:   return g ? 2'b10 : (t ? 2'b11 : 2'b00);
      default: return t ? 2'b11 : 2'b00;
    endcase
  endfunction

  task automatic chk(string tag, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic tick();
    logic [1:0] nc;
    prev_code = code;
    if (rst) begin
      nc = tog ? 2'b11 : 2'b00;
      m_dbl = 1'b0;
    end else begin
      nc = m_dbl ? m_code : step_code(m_code, m_g, m_t);
      m_dbl = (gate != m_g) && (tog != m_t);
    end
    m_code = nc;
    m_g = gate;
    m_t = tog;
    @(posedge clk);
    #1;
  endtask

  task automatic model_chk();
    chk("R7 code vs model", code, m_code);
    chk("R2 hit vs model", {1'b0, hit}, {1'b0, m_g && (m_code == 2'b10)});
    if (!rst) chk("R6 single bit step", 2'($countones(code ^ prev_code) <= 1), 2'd1);
  endtask

  task automatic do_reset(logic g, logic t);
    rst = 1'b1; gate = g; tog = t;
    tick(); tick();
    chk("R1 reset code", code, t ? 2'b11 : 2'b00);
    chk("R1 reset hit", {1'b0, hit}, 2'b00);
    rst = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    m_code = 2'b00; m_g = 1'b0; m_t = 1'b0; m_dbl = 1'b0; prev_code = 2'b00;
    #1;
    do_reset(1'b0, 1'b1);
    do_reset(1'b0, 1'b0);

    // gate alone rises: no arming
    gate = 1'b1; tick(); model_chk(); tick();
    chk("R8 gate rise keeps hit low", {1'b0, hit}, 2'b00);
    // toggle rises under gate
    tog = 1'b1; tick();
    chk("R3 one edge after change still low", {1'b0, hit}, 2'b00);
    tick();
    chk("R3 rising toggle sets code", code, 2'b10);
    chk("R3 rising toggle sets hit", {1'b0, hit}, 2'b01);
    tog = 1'b0; tick(); tick();
    chk("R4 hold after toggle fall", {1'b0, hit}, 2'b01);
    tog = 1'b1; tick(); tick();
    chk("R4 hold after toggle rise", {1'b0, hit}, 2'b01);
    // gate falls
    gate = 1'b0; tick();
    chk("R5 gate fall clears hit", {1'b0, hit}, 2'b00);
    tick();
    chk("R7 set to idle-high", code, 2'b11);
    // falling toggle under gate
    gate = 1'b1; tick(); tick();
    chk("R8 gate rise from idle-high", {1'b0, hit}, 2'b00);
    tog = 1'b0; tick(); tick();
    chk("R3 falling toggle sets hit", {1'b0, hit}, 2'b01);
    gate = 1'b0; tick(); tick();
    chk("R7 set to idle-low", code, 2'b00);
    // toggle moves with gate low: middle step, no pulse
    tog = 1'b1; tick(); tick();
    chk("R7 middle step code", code, 2'b10);
    chk("R2 no pulse on middle step", {1'b0, hit}, 2'b00);
    tick();
    chk("R7 reaches idle-high", code, 2'b11);
    // double change 01 -> 10
    gate = 1'b1; tog = 1'b0; tick();
    chk("R9 first edge code", code, 2'b11);
    tick();
    chk("R9 frozen code", code, 2'b11);
    chk("R9 frozen hit", {1'b0, hit}, 2'b00);
    tick();
    chk("R9 steps after freeze", code, 2'b10);
    chk("R9 hit after freeze", {1'b0, hit}, 2'b01);

    // constrained random: mostly single changes, rare double
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 2)       begin gate = ~gate; tog = ~tog; end
      else if (r < 20) gate = ~gate;
      else if (r < 45) tog = ~tog;
      if ($urandom_range(0, 999) == 0) begin
        do_reset(gate, tog);
      end else begin
        tick();
        model_chk();
      end
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule